// File: doc/BRIEF.md
# Decimal Accumulator Stored-Program Processor

This block is a small processor built around one accumulator. It runs a program held in the same memory as its data. Every word is three decimal digits, stored as binary-coded decimal in 12 bits. The upper digit of an instruction word selects the operation. The lower two digits give a memory address in the range 00 to 99. Inside the block are a program counter, an instruction register, a memory address register, a memory data register, the accumulator with a negative flag, and a controller that steps through fetch, decode and execute in strict sequence.

The block drives an external synchronous memory of 100 words. It uses an address port, a write-data port and a write strobe, and it takes the memory's registered read data back in. Once reset is released, the processor waits until `run` is high and then repeats the fetch/execute loop. It stops on a halt instruction or an unknown opcode and stays stopped until the next reset. The accumulator value and its sign flag are brought out for observation.

Top module: `dcpu_core`

## Requirements
- R1: While `rst_n` is low and after it is released, `acc` reads 000, `acc_neg` is 0, `halted` and `illegal` are 0, `mem_we` is 0 and `mem_addr` is 00. The first instruction is fetched from address 00.
- R2: While the controller is between instructions and `run` is low, no fetch begins. `acc` holds its value and `mem_we` stays low. Fetching resumes on the first clock edge that sees `run` high.
- R3: An instruction word is the opcode digit in bits 11:8 followed by a two-digit BCD address in bits 7:0 (tens in 7:4). To fetch, the processor puts the program counter on `mem_addr` and adds one to the counter, with 99 wrapping to 00. It then waits one cycle for the memory read. During decode, the instruction's address field is placed on `mem_addr`.
- R4: Opcode 1 (add) replaces the accumulator with accumulator plus memory at the address. The sum uses decimal digit carries, wraps modulo 1000, and clears `acc_neg`.
- R5: Opcode 2 (subtract) replaces the accumulator with accumulator minus memory at the address. The difference uses decimal digit borrows and wraps modulo 1000. `acc_neg` is set exactly when the subtraction underflows.
- R6: Opcode 5 (load) copies memory at the address into the accumulator and clears `acc_neg`. Opcode 3 (store) raises `mem_we` for one cycle with the accumulator on `mem_wdata` and the address on `mem_addr`.
- R7: Opcode 6 always loads the address into the program counter. Opcode 7 does so only when the accumulator is 000 and `acc_neg` is 0. Opcode 8 does so only when the accumulator is non-zero and `acc_neg` is 0.
- R8: Opcode 0 raises `halted` with `illegal` low. After that, `halted` stays high, `acc` is unchanged and no memory write occurs until reset.
- R9: Opcodes 4 and 9 halt the processor as in R8 and also raise `illegal`.
- R10: Counted in clock edges from the between-instructions state, an instruction takes 6 edges for branch and halt opcodes, 7 for store and 9 for add, subtract and load. The accumulator takes its new value on the 9th edge. The store strobe is high in the cycle after the 6th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Allows the next instruction fetch to start |
| mem_addr | output | 8 | Memory address, two BCD digits |
| mem_wdata | output | 12 | Store data, three BCD digits |
| mem_rdata | input | 12 | Registered memory read data, one cycle after the address |
| mem_we | output | 1 | Memory write strobe |
| halted | output | 1 | Processor has stopped |
| illegal | output | 1 | The stop was caused by an unknown opcode |
| acc | output | 12 | Accumulator, three BCD digits |
| acc_neg | output | 1 | Last subtraction underflowed |

## Verification
The cases hardest to reach from the ports are the sign-dependent branches and the program-counter wrap. Reaching a negative accumulator takes a subtract that borrows through every digit. Reaching a wrap takes a program whose flow passes through address 99. The stimulus uses a countdown loop that subtracts to zero, then subtracts once more to get 999 with the negative flag set. It then tests both conditional branches on zero, negative and positive accumulators. A separate program jumps to 98 and runs off the top of memory back to 00, where the same conditional branch is taken on one pass and not taken on the next. Every clock is compared against an instruction-level decimal model whose cycle counts come from R10.

// File: rtl/dcpu_pkg.sv
package dcpu_pkg;
  localparam int WORD_DIGITS = 3;
  localparam int ADDR_DIGITS = 2;
  localparam int WORD_W      = 4 * WORD_DIGITS;
  localparam int ADDR_W      = 4 * ADDR_DIGITS;
  localparam int OPC_W       = WORD_W - ADDR_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [OPC_W-1:0]  opc_t;

  localparam opc_t OP_HLT = opc_t'(0);
  localparam opc_t OP_ADD = opc_t'(1);
  localparam opc_t OP_SUB = opc_t'(2);
  localparam opc_t OP_STA = opc_t'(3);
  localparam opc_t OP_LDA = opc_t'(5);
  localparam opc_t OP_BR  = opc_t'(6);
  localparam opc_t OP_BRZ = opc_t'(7);
  localparam opc_t OP_BRP = opc_t'(8);

  typedef enum logic [3:0] {
    ST_IDLE, ST_FADR, ST_FWAIT, ST_FRD, ST_FIR, ST_DEC,
    ST_XWAIT, ST_XRD, ST_XALU, ST_STW, ST_HALT
  } state_t;

  typedef enum logic [1:0] { ALU_PASS, ALU_ADD, ALU_SUB } alu_op_t;

  // BCD increment with wrap from all nines to zero
  function automatic addr_t addr_inc(addr_t a);
    addr_t      r;
    logic       c;
    logic [3:0] d;
    c = 1'b1;
    for (int i = 0; i < ADDR_DIGITS; i++) begin
      d = a[4*i +: 4];
      if (c) begin
        if (d == 4'd9) d = 4'd0;
        else begin
          d = d + 4'd1;
          c = 1'b0;
        end
      end
      r[4*i +: 4] = d;
    end
    return r;
  endfunction

  function automatic logic word_is_bcd(word_t w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < WORD_DIGITS; i++)
      if (w[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/dcpu_bcd_alu.sv
module dcpu_bcd_alu
  import dcpu_pkg::*;
(
  input  alu_op_t op,
  input  word_t   a,
  input  word_t   b,
  output word_t   y,
  output logic    neg
);
  // carry for add, borrow for subtract
  logic [WORD_DIGITS:0] cy;
  assign cy[0] = 1'b0;

  for (genvar gi = 0; gi < WORD_DIGITS; gi++) begin : g_digit
    logic [3:0] da, db, dig;
    logic [4:0] sum, dif;
    logic       co;

    assign da = a[4*gi +: 4];
    assign db = b[4*gi +: 4];

    always_comb begin
      sum = {1'b0, da} + {1'b0, db} + {4'd0, cy[gi]};
      dif = {1'b0, da} - {1'b0, db} - {4'd0, cy[gi]};
      dig = db;
      co  = 1'b0;
      case (op)
        ALU_ADD: begin
          if (sum > 5'd9) begin
            dig = sum[3:0] + 4'd6;
            co  = 1'b1;
          end else begin
            dig = sum[3:0];
          end
        end
        ALU_SUB: begin
          if (dif[4]) begin
            dig = dif[3:0] + 4'd10;
            co  = 1'b1;
          end else begin
            dig = dif[3:0];
          end
        end
        default: begin
          dig = db;
          co  = 1'b0;
        end
      endcase
    end

    assign y[4*gi +: 4] = dig;
    assign cy[gi+1]     = co;
  end

  assign neg = (op == ALU_SUB) && cy[WORD_DIGITS];
endmodule

// File: rtl/dcpu_ctrl.sv
module dcpu_ctrl
  import dcpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_s,
  input  logic    run,
  input  opc_t    opc,
  input  logic    acc_zero,
  input  logic    acc_neg,
  output logic    ld_mar_pc,
  output logic    ld_mar_ir,
  output logic    pc_inc,
  output logic    pc_load,
  output logic    ld_mdr,
  output logic    ld_ir,
  output logic    ld_acc,
  output alu_op_t alu_op,
  output logic    mem_we,
  output logic    halted,
  output logic    illegal,
  output logic    idle
);
  state_t state_q, state_d;
  logic   ill_q, set_ill;

  always_comb begin
    state_d   = state_q;
    ld_mar_pc = 1'b0;
    ld_mar_ir = 1'b0;
    pc_inc    = 1'b0;
    pc_load   = 1'b0;
    ld_mdr    = 1'b0;
    ld_ir     = 1'b0;
    ld_acc    = 1'b0;
    mem_we    = 1'b0;
    set_ill   = 1'b0;
    alu_op    = ALU_PASS;
    case (state_q)
      ST_IDLE:  if (run) state_d = ST_FADR;
      ST_FADR: begin
        ld_mar_pc = 1'b1;
        pc_inc    = 1'b1;
        state_d   = ST_FWAIT;
      end
      ST_FWAIT: state_d = ST_FRD;
      ST_FRD: begin
        ld_mdr  = 1'b1;
        state_d = ST_FIR;
      end
      ST_FIR: begin
        ld_ir   = 1'b1;
        state_d = ST_DEC;
      end
      ST_DEC: begin
        ld_mar_ir = 1'b1;
        state_d   = ST_IDLE;
        case (opc)
          OP_HLT:                 state_d = ST_HALT;
          OP_ADD, OP_SUB, OP_LDA: state_d = ST_XWAIT;
          OP_STA:                 state_d = ST_STW;
          OP_BR:                  pc_load = 1'b1;
          OP_BRZ:                 pc_load = acc_zero && !acc_neg;
          OP_BRP:                 pc_load = !acc_zero && !acc_neg;
          default: begin
            state_d = ST_HALT;
            set_ill = 1'b1;
          end
        endcase
      end
      ST_XWAIT: state_d = ST_XRD;
      ST_XRD: begin
        ld_mdr  = 1'b1;
        state_d = ST_XALU;
      end
      ST_XALU: begin
        ld_acc  = 1'b1;
        alu_op  = (opc == OP_ADD) ? ALU_ADD :
                  (opc == OP_SUB) ? ALU_SUB : ALU_PASS;
        state_d = ST_IDLE;
      end
      ST_STW: begin
        mem_we  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (set_ill) ill_q <= 1'b1;
    end
  end

  assign halted  = (state_q == ST_HALT);
  assign illegal = ill_q;
  assign idle    = (state_q == ST_IDLE);

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_s)
    halted |=> halted);                                            // R8
  AST_ILLEGAL_HALTS: assert property (@(posedge clk) disable iff (!rst_s)
    illegal |-> halted);                                           // R9
  AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rst_s)
    halted |-> !mem_we);                                           // R8
endmodule

// File: rtl/dcpu_core.sv
module dcpu_core
  import dcpu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                mem_we,
  output logic                halted,
  output logic                illegal,
  output logic [WORD_W-1:0]   acc,
  output logic                acc_neg
);
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  addr_t   pc_q, mar_q;
  word_t   mdr_q, ir_q, acc_q, alu_y;
  logic    neg_q, alu_neg;
  logic    ld_mar_pc, ld_mar_ir, pc_inc, pc_load, ld_mdr, ld_ir, ld_acc;
  logic    idle;
  alu_op_t alu_op;
  opc_t    opc;
  addr_t   ir_addr;

  assign opc     = ir_q[WORD_W-1:ADDR_W];
  assign ir_addr = ir_q[ADDR_W-1:0];

  dcpu_ctrl u_ctrl (
    .clk       (clk),
    .rst_s     (rst_s),
    .run       (run),
    .opc       (opc),
    .acc_zero  (acc_q == '0),
    .acc_neg   (neg_q),
    .ld_mar_pc (ld_mar_pc),
    .ld_mar_ir (ld_mar_ir),
    .pc_inc    (pc_inc),
    .pc_load   (pc_load),
    .ld_mdr    (ld_mdr),
    .ld_ir     (ld_ir),
    .ld_acc    (ld_acc),
    .alu_op    (alu_op),
    .mem_we    (mem_we),
    .halted    (halted),
    .illegal   (illegal),
    .idle      (idle)
  );

  dcpu_bcd_alu u_alu (
    .op  (alu_op),
    .a   (acc_q),
    .b   (mdr_q),
    .y   (alu_y),
    .neg (alu_neg)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      neg_q <= 1'b0;
    end else begin
      if (ld_mar_pc)      mar_q <= pc_q;
      else if (ld_mar_ir) mar_q <= ir_addr;
      if (pc_inc)         pc_q  <= addr_inc(pc_q);
      else if (pc_load)   pc_q  <= ir_addr;
      if (ld_mdr)         mdr_q <= mem_rdata;
      if (ld_ir)          ir_q  <= mdr_q;
      if (ld_acc) begin
        acc_q <= alu_y;
        neg_q <= alu_neg;
      end
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = acc_q;
  assign acc       = acc_q;
  assign acc_neg   = neg_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (idle && !run) |=> ($stable(acc_q) && !mem_we));               // R2
  AST_ACC_DECIMAL: assert property (@(posedge clk) disable iff (!rst_s)
    word_is_bcd(acc_q));                                           // R4
  AST_NEG_NONZERO: assert property (@(posedge clk) disable iff (!rst_s)
    neg_q |-> (acc_q != '0));                                      // R5
  AST_PC_DECIMAL: assert property (@(posedge clk) disable iff (!rst_s)
    pc_inc |=> (pc_q[3:0] <= 4'd9 && pc_q[ADDR_W-1:ADDR_W-4] <= 4'd9)); // R3
endmodule

// File: tb/dcpu_core_test.sv
`timescale 1ns/100ps
module dcpu_core_test;
  import dcpu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n, run;
  logic [7:0]  mem_addr;
  logic [11:0] mem_wdata, mem_rdata;
  logic        mem_we, halted, illegal, acc_neg;
  logic [11:0] acc;

  always #2.5 clk = ~clk;

  dcpu_core uut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .halted(halted), .illegal(illegal),
    .acc(acc), .acc_neg(acc_neg)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  function automatic int bidx(logic [7:0] a);
    return int'(a[7:4]) * 10 + int'(a[3:0]);
  endfunction

  function automatic logic [11:0] to_bcd(int v);
    return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  // bench memory, synchronous read
  logic [11:0] ram [100];
  logic        ld_en = 1'b0;
  int          ld_idx = 0;
  logic [11:0] ld_word = '0;

  always @(posedge clk) begin
    if (ld_en) ram[ld_idx] <= ld_word;
    else if (mem_we) ram[bidx(mem_addr)] <= mem_wdata;
    mem_rdata <= ram[bidx(mem_addr)];
  end

  // reference model state
  int mm [100];
  int m_acc, m_pc;
  bit m_neg, m_halt, m_ill;

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(string req, bit we_exp);
    chk(req, "acc", int'(acc), int'(to_bcd(m_acc)));
    chk(req, "acc_neg", int'(acc_neg), int'(m_neg));
    chk(req, "halted", int'(halted), int'(m_halt));
    chk(req, "illegal", int'(illegal), int'(m_ill));
    chk(req, "mem_we", int'(mem_we), int'(we_exp));
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 100; i++) mm[i] = 0;
  endtask

  task automatic load_and_reset();
    rst_n = 1'b0;
    run   = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = i; ld_word = to_bcd(mm[i]);
    end
    @(negedge clk);
    ld_en = 1'b0;
    m_acc = 0; m_pc = 0; m_neg = 0; m_halt = 0; m_ill = 0;
    check_outputs("R1", 1'b0);
    chk("R1", "mem_addr in reset", int'(mem_addr), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outputs("R1", 1'b0);
    chk("R1", "mem_addr after reset", int'(mem_addr), 0);
    run = 1'b1;
  endtask

  task automatic step_insn();
    int w, op, ad, n, fetch_at, r;
    string tag;
    bit taken;
    w = mm[m_pc]; op = w / 100; ad = w % 100;
    fetch_at = m_pc;
    m_pc = (m_pc + 1) % 100;
    case (op)
      1, 2, 5: n = 9;
      3:       n = 7;
      default: n = 6;
    endcase
    case (op)
      1: tag = "R4"; 2: tag = "R5"; 3, 5: tag = "R6";
      6, 7, 8: tag = "R7"; 0: tag = "R8"; default: tag = "R9";
    endcase
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k == n) begin
        case (op)
          1: begin m_acc = (m_acc + mm[ad]) % 1000; m_neg = 0; end
          2: begin
            r = m_acc - mm[ad];
            m_neg = (r < 0);
            m_acc = (r < 0) ? r + 1000 : r;
          end
          5: begin m_acc = mm[ad]; m_neg = 0; end
          3: mm[ad] = m_acc;
          6: m_pc = ad;
          7: begin taken = (m_acc == 0) && !m_neg; if (taken) m_pc = ad; end
          8: begin taken = (m_acc != 0) && !m_neg; if (taken) m_pc = ad; end
          0: m_halt = 1;
          default: begin m_halt = 1; m_ill = 1; end
        endcase
      end
      if (k == 2) chk("R3", "fetch address", int'(mem_addr), int'(to_bcd(fetch_at)));
      if (k == 6) chk("R3", "operand address", int'(mem_addr), int'(to_bcd(ad)));
      if (op == 3 && k == 6)
        chk("R6", "store data", int'(mem_wdata), int'(to_bcd(m_acc)));
      check_outputs((k == n) ? tag : "R10", (op == 3) && (k == 6));
      if (op == 3 && k == n)
        chk("R6", "stored word", int'(ram[ad]), int'(to_bcd(mm[ad])));
    end
  endtask

  task automatic pause_run(int cycles);
    run = 1'b0;
    repeat (cycles) begin
      @(negedge clk);
      check_outputs("R2", 1'b0);
    end
    run = 1'b1;
  endtask

  task automatic run_to_halt(int pause_before);
    int cnt = 0;
    while (!m_halt && cnt < 300) begin
      if (cnt == pause_before) pause_run(7);
      step_insn();
      cnt++;
    end
    // sticky halt: nothing moves afterwards
    repeat (8) begin
      @(negedge clk);
      check_outputs("R8", 1'b0);
    end
  endtask

  task automatic final_mem_check(string req);
    for (int i = 0; i < 100; i++)
      if (ram[i] != to_bcd(mm[i])) chk(req, "final memory word", int'(ram[i]), int'(to_bcd(mm[i])));
    chk(req, "final memory scan", 0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    run   = 1'b0;

    // Program A: load, decimal add with carries, store, add that wraps, store
    clear_prog();
    mm[0] = 510; mm[1] = 111; mm[2] = 312; mm[3] = 111; mm[4] = 313; mm[5] = 0;
    mm[10] = 478; mm[11] = 356;
    load_and_reset();
    run_to_halt(2);
    final_mem_check("R6");
    chk("R4", "sum 478+356+356 mod 1000", int'(acc), int'(to_bcd(190)));

    // Program B: countdown loop, underflow, sign-dependent branches
    clear_prog();
    mm[0] = 520; mm[1] = 221; mm[2] = 706; mm[3] = 601;
    mm[6] = 221; mm[7] = 810; mm[8] = 711; mm[9] = 522;
    mm[10] = 812; mm[11] = 0; mm[12] = 223; mm[13] = 815; mm[14] = 0;
    mm[20] = 3; mm[21] = 1; mm[22] = 5; mm[23] = 5;
    load_and_reset();
    run_to_halt(-1);
    chk("R5", "final accumulator zero", int'(acc), 0);

    // Program C: program counter runs past 99 back to 00
    clear_prog();
    mm[0] = 798; mm[1] = 0; mm[98] = 550; mm[99] = 151;
    mm[50] = 7; mm[51] = 1;
    load_and_reset();
    run_to_halt(-1);
    chk("R3", "accumulator after wrap", int'(acc), int'(to_bcd(8)));

    // Program D: unknown opcode 4
    clear_prog();
    mm[0] = 540; mm[1] = 400; mm[40] = 12;
    load_and_reset();
    run_to_halt(-1);
    chk("R9", "illegal flag for opcode 4", int'(illegal), 1);

    // Program E: unknown opcode 9 as first word
    clear_prog();
    mm[0] = 900;
    load_and_reset();
    run_to_halt(-1);
    chk("R9", "illegal flag for opcode 9", int'(illegal), 1);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      vectors++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule